// File: doc/BRIEF.md
# Packet Tree Merger

This block gathers framed packets from a set of channel queues and sends them out as one stream. Each channel has a word queue that a producer fills over a valid/ready handshake. A test load port can also fill any queue directly. The queues feed the leaves of a binary tree of identical merge stages. Each stage holds exactly one packet. It collects a whole packet from one of its two children, and only then passes that packet towards the root. The root stage drives the output port, and a downstream stall reaches every stage through its ready signal.

A stage chooses between its two children with a local round-robin rule. When both children offer a packet, it serves the child it did not serve last. When only one child offers a packet, it serves that child at once. A stage starts taking a new packet while it sends the last word of its current packet. Words of different packets never interleave on the output, and packets from one channel leave in the order they entered. The channel count is a parameter. A count that is not a power of two is padded up with leaves that never offer data.

Top module: `pkt_tree_merger`

## Requirements
- R1: After reset `out_valid` is low, every `in_ready` bit is high and every `load_drop` bit is low.
- R2: The output carries every accepted word exactly once. Words of one channel keep their entry order, and a packet's words leave back to back, with no word of another packet between them (`out_last` marks the final word).
- R3: When both children of a stage offer a packet, the stage serves the child it did not serve most recently; after reset the left (lower-numbered) child goes first. Two sibling channels loaded with equal packet counts therefore leave strictly alternating, starting with the lower channel.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values on the next cycle.
- R5: Each channel queue holds FIFO_PKTS×MAX_LEN words (160 by default). A full queue drives its `in_ready` bit low, and the other channels are not affected.
- R6: A load-port write (`ld_en` high) goes to the channel `ld_ch` in place of that channel's normal input, and forces that channel's `in_ready` low for the cycle. A loaded word travels like a normal one.
- R7: A load-port write to a full queue is discarded and sets that channel's `load_drop` bit. The bit stays set until reset, and the other bits do not change.
- R8: Each merge stage stores one packet. With the output stalled, one channel therefore takes queue depth plus one packet per tree level before its queue is full (163 single-word packets by default).
- R9: Packets of 1 to MAX_LEN (10) words pass intact. No packet leaves with more than MAX_LEN words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | NUM_CH | Per-channel word valid |
| in_data | input | NUM_CH×WORD_W | Per-channel word; channel k is at bits k×WORD_W and up |
| in_last | input | NUM_CH | Per-channel end-of-packet marker |
| in_ready | output | NUM_CH | Per-channel ready; low when the queue is full or a load write targets it |
| ld_en | input | 1 | Load-port write strobe |
| ld_ch | input | CH_W | Load-port target channel |
| ld_data | input | WORD_W | Load-port word |
| ld_last | input | 1 | Load-port end-of-packet marker |
| out_valid | output | 1 | Output word valid |
| out_data | output | WORD_W | Output word |
| out_last | output | 1 | Output end-of-packet marker |
| out_ready | input | 1 | Downstream ready |
| load_drop | output | NUM_CH | Sticky per-channel flag: a load write was discarded |

## Verification
The hardest situation to reach is a channel queue exactly at its limit while every stage on its path holds a packet. Queue occupancy cannot be seen at the ports, and the stages keep pulling words out of the queue. The bench stalls the output, then writes single-word packets through the load port one per cycle. It checks that the drop flag stays clear through the 163rd write and sets on the 164th, and after release it checks that exactly 163 packets come out. The arbitration case where both siblings are pending is reached by interleaving load writes to two sibling channels while the output is stalled. A random `out_ready` pattern then exercises stall behaviour while all channels stream packets of 1 to 10 words.

// File: rtl/pktm_pkg.sv
// Shared types for the packet tree merger.
package pktm_pkg;
    // Merge stage occupancy: empty, collecting a packet, offering it upward.
    typedef enum logic [1:0] {
        ND_IDLE = 2'd0,
        ND_RECV = 2'd1,
        ND_SEND = 2'd2
    } node_state_e;
endpackage

// File: rtl/pktm_chan_fifo.sv
// Per-channel word queue.
// Stores DEPTH words, each with its end-of-packet bit in the MSB.
// Assumes: the writer checks `full` itself; a write while full is ignored here.
module pktm_chan_fifo #(
    parameter int WORD_W = 24,
    parameter int DEPTH  = 160
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W:0]   wr_word,
    output logic              full,
    output logic              rd_valid,
    output logic [WORD_W:0]   rd_word,
    input  logic              rd_en
);
    localparam int AW = $clog2(DEPTH + 1);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WORD_W:0] mem [DEPTH];
    logic [PW-1:0]   wr_ptr;
    logic [PW-1:0]   rd_ptr;
    logic [AW-1:0]   count;
    logic            do_wr;
    logic            do_rd;

    assign full     = (count == AW'(DEPTH));
    assign rd_valid = (count != '0);
    assign rd_word  = mem[rd_ptr];
    assign do_wr    = wr_en && !full;
    assign do_rd    = rd_en && rd_valid;

    // Storage write, no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_word;
    end

    // Pointer and occupancy update with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + AW'(do_wr) - AW'(do_rd);
        end
    end
endmodule

// File: rtl/pktm_merge_node.sv
// One merge stage of the tree.
// Collects one whole packet from the left or right child, then offers it
// upward word by word. Round robin: if both children offer, the child not
// served last wins; a lone offering child is taken at once. A new packet is
// accepted while the final word of the held packet leaves.
// Assumes: packets are at most MAX_LEN words (longer ones overwrite the tail).
module pktm_merge_node
    import pktm_pkg::*;
#(
    parameter int WORD_W  = 24,
    parameter int MAX_LEN = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_valid,
    input  logic [WORD_W:0]   l_word,
    output logic              l_ready,
    input  logic              r_valid,
    input  logic [WORD_W:0]   r_word,
    output logic              r_ready,
    output logic              o_valid,
    output logic [WORD_W:0]   o_word,
    input  logic              o_ready
);
    localparam int IW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

    node_state_e     state;
    logic [WORD_W:0] buf_q [MAX_LEN];
    logic [IW-1:0]   wptr;
    logic [IW-1:0]   rptr;
    logic            src_q;
    logic            last_src_q;

    logic            drain_end;
    logic            can_take;
    logic            take;
    logic            pick;
    logic            sel;
    logic            in_open;
    logic            in_fire;
    logic [WORD_W:0] in_word;
    logic            in_last;
    logic [IW-1:0]   widx;
    logic            o_fire;

    assign o_valid = (state == ND_SEND);
    assign o_word  = buf_q[rptr];
    assign o_fire  = o_valid && o_ready;

    // Arbitration and child handshake selection.
    always_comb begin
        drain_end = o_fire && buf_q[rptr][WORD_W];
        can_take  = (state == ND_IDLE) || drain_end;
        take      = can_take && (l_valid || r_valid);
        pick      = (l_valid && r_valid) ? ~last_src_q : r_valid;
        sel       = (state == ND_RECV) ? src_q : pick;
        in_open   = (state == ND_RECV) || take;
        l_ready   = in_open && !sel;
        r_ready   = in_open && sel;
        in_word   = sel ? r_word : l_word;
        in_fire   = in_open && (sel ? r_valid : l_valid);
        in_last   = in_word[WORD_W];
        widx      = take ? '0 : wptr;
    end

    // Packet storage write.
    always_ff @(posedge clk) begin
        if (in_fire) buf_q[widx] <= in_word;
    end

    // Stage state, pointers and round-robin memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ND_IDLE;
            wptr       <= '0;
            rptr       <= '0;
            src_q      <= 1'b0;
            last_src_q <= 1'b1;
        end else begin
            if (take) begin
                src_q      <= pick;
                last_src_q <= pick;
            end
            if (in_fire) begin
                if (in_last)                          wptr <= '0;
                else if (widx == IW'(MAX_LEN - 1))    wptr <= widx;
                else                                  wptr <= widx + 1'b1;
            end
            if (o_fire) rptr <= drain_end ? '0 : rptr + 1'b1;
            case (state)
                ND_IDLE: if (in_fire) state <= in_last ? ND_SEND : ND_RECV;
                ND_RECV: if (in_fire && in_last) state <= ND_SEND;
                ND_SEND: if (drain_end) begin
                    if (in_fire) state <= in_last ? ND_SEND : ND_RECV;
                    else         state <= ND_IDLE;
                end
                default: state <= ND_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pkt_tree_merger.sv
// Top of the packet tree merger.
// Channel queues feed the leaves of a binary tree of merge stages stored in
// heap order: stage n has children 2n and 2n+1, the root is stage 1, leaf k
// sits at index NLEAF+k. Leaves past NUM_CH never offer data.
// A load-port write replaces the normal input of its channel for one cycle;
// one that meets a full queue is dropped and flagged.
// Assumes: NUM_CH >= 2, MAX_LEN >= 2, packets no longer than MAX_LEN words.
module pkt_tree_merger #(
    parameter  int NUM_CH    = 8,
    parameter  int WORD_W    = 24,
    parameter  int MAX_LEN   = 10,
    parameter  int FIFO_PKTS = 16,
    localparam int CH_W      = $clog2(NUM_CH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        in_valid,
    input  logic [NUM_CH*WORD_W-1:0] in_data,
    input  logic [NUM_CH-1:0]        in_last,
    output logic [NUM_CH-1:0]        in_ready,
    input  logic                     ld_en,
    input  logic [CH_W-1:0]          ld_ch,
    input  logic [WORD_W-1:0]        ld_data,
    input  logic                     ld_last,
    output logic                     out_valid,
    output logic [WORD_W-1:0]        out_data,
    output logic                     out_last,
    input  logic                     out_ready,
    output logic [NUM_CH-1:0]        load_drop
);
    localparam int LVL   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int NLEAF = 1 << LVL;
    localparam int NIDX  = 2 * NLEAF;
    localparam int DEPTH = FIFO_PKTS * MAX_LEN;

    logic [NIDX-1:1]  nd_valid;
    logic [NIDX-1:1]  nd_ready;
    logic [WORD_W:0]  nd_word [1:NIDX-1];

    logic [NUM_CH-1:0] ld_hit;
    logic [NUM_CH-1:0] q_full;
    logic [NUM_CH-1:0] drop_q;

    // Leaf side: one queue per live channel, idle padding above NUM_CH.
    for (genvar k = 0; k < NLEAF; k++) begin : g_leaf
        if (k < NUM_CH) begin : g_live
            logic [WORD_W:0] wr_word;
            assign ld_hit[k]   = ld_en && (ld_ch == CH_W'(k));
            assign wr_word     = ld_hit[k] ? {ld_last, ld_data}
                                           : {in_last[k], in_data[k*WORD_W +: WORD_W]};
            assign in_ready[k] = !q_full[k] && !ld_hit[k];

            pktm_chan_fifo #(
                .WORD_W (WORD_W),
                .DEPTH  (DEPTH)
            ) u_q (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_en    (ld_hit[k] || in_valid[k]),
                .wr_word  (wr_word),
                .full     (q_full[k]),
                .rd_valid (nd_valid[NLEAF+k]),
                .rd_word  (nd_word[NLEAF+k]),
                .rd_en    (nd_ready[NLEAF+k])
            );
        end else begin : g_pad
            assign nd_valid[NLEAF+k] = 1'b0;
            assign nd_word[NLEAF+k]  = '0;
        end
    end

    // Interior stages in heap order.
    for (genvar n = 1; n < NLEAF; n++) begin : g_node
        pktm_merge_node #(
            .WORD_W  (WORD_W),
            .MAX_LEN (MAX_LEN)
        ) u_node (
            .clk     (clk),
            .rst_n   (rst_n),
            .l_valid (nd_valid[2*n]),
            .l_word  (nd_word[2*n]),
            .l_ready (nd_ready[2*n]),
            .r_valid (nd_valid[2*n+1]),
            .r_word  (nd_word[2*n+1]),
            .r_ready (nd_ready[2*n+1]),
            .o_valid (nd_valid[n]),
            .o_word  (nd_word[n]),
            .o_ready (nd_ready[n])
        );
    end

    assign nd_ready[1] = out_ready;
    assign out_valid   = nd_valid[1];
    assign out_data    = nd_word[1][WORD_W-1:0];
    assign out_last    = nd_word[1][WORD_W];
    assign load_drop   = drop_q;

    // Sticky record of load writes that met a full queue.
    always_ff @(posedge clk) begin
        if (!rst_n) drop_q <= '0;
        else        drop_q <= drop_q | (ld_hit & q_full);
    end
endmodule

// File: rtl/pkt_tree_merger_chk.sv
// Property checker for the packet tree merger, bound to the top module.
// Watches only ports; counts output words per packet to bound packet length.
module pkt_tree_merger_chk #(
    parameter int NUM_CH  = 8,
    parameter int WORD_W  = 24,
    parameter int MAX_LEN = 10,
    parameter int CH_W    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] in_ready,
    input logic              ld_en,
    input logic [CH_W-1:0]   ld_ch,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_data,
    input logic              out_last,
    input logic              out_ready,
    input logic [NUM_CH-1:0] load_drop
);
    localparam int CW = $clog2(MAX_LEN + 1);
    logic [CW-1:0] word_idx;

    // Position of the current output word inside its packet.
    always_ff @(posedge clk) begin
        if (!rst_n)                        word_idx <= '0;
        else if (out_valid && out_ready)   word_idx <= out_last ? '0 : word_idx + 1'b1;
    end

    assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    assert_drop_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|load_drop) |=> ((load_drop & $past(load_drop)) == $past(load_drop)));

    assert_load_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |-> !in_ready[ld_ch]);

    assert_pkt_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_last) |-> (word_idx < CW'(MAX_LEN - 1)));
endmodule

bind pkt_tree_merger pkt_tree_merger_chk #(
    .NUM_CH  (NUM_CH),
    .WORD_W  (WORD_W),
    .MAX_LEN (MAX_LEN),
    .CH_W    (CH_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .ld_en     (ld_en),
    .ld_ch     (ld_ch),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .out_ready (out_ready),
    .load_drop (load_drop)
);

// File: tb/pkt_tree_merger_bench.sv
// Bench: per-channel expected word queues, compared on every clock at the
// output; stall stability checked each cycle. Word format used by the bench:
// [23:20] channel, [19:12] sequence, [11:8] word index, [7:0] packet length.
module pkt_tree_merger_bench;
    localparam int NCH   = 8;
    localparam int WW    = 24;
    localparam int ML    = 10;
    localparam int FP    = 16;
    localparam int DEPTH = FP * ML;
    localparam int LEVELS = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic [NCH-1:0]    in_valid = '0;
    logic [NCH*WW-1:0] in_data = '0;
    logic [NCH-1:0]    in_last = '0;
    logic [NCH-1:0]    in_ready;
    logic              ld_en = 1'b0;
    logic [2:0]        ld_ch = '0;
    logic [WW-1:0]     ld_data = '0;
    logic              ld_last = 1'b0;
    logic              out_valid;
    logic [WW-1:0]     out_data;
    logic              out_last;
    logic              out_ready;
    logic [NCH-1:0]    load_drop;

    logic fixed_ready = 1'b0;
    logic rand_mode = 1'b0;
    logic rnd_bit = 1'b0;
    assign out_ready = rand_mode ? rnd_bit : fixed_ready;

    pkt_tree_merger u_pkt_tree_merger (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .ld_en(ld_en), .ld_ch(ld_ch), .ld_data(ld_data), .ld_last(ld_last),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last),
        .out_ready(out_ready), .load_drop(load_drop)
    );

    int checks = 0;
    int errors = 0;
    int cycle  = 0;
    logic [WW:0] expq [NCH][$];
    int done_ch [$];
    logic mid = 1'b0;
    int cur_ch = 0;
    logic pv = 1'b0;
    logic pr = 1'b0;
    logic [WW:0] pw = '0;

    function automatic logic [WW-1:0] mk(int ch, int seq, int idx, int len);
        return {ch[3:0], seq[7:0], idx[3:0], len[7:0]};
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit all_empty();
        for (int c = 0; c < NCH; c++) if (expq[c].size() != 0) return 1'b0;
        return 1'b1;
    endfunction

    // Random backpressure source.
    always @(negedge clk) rnd_bit <= 1'($urandom_range(0, 1));

    // Output monitor and watchdog, sampled between edges.
    always @(negedge clk) begin
        logic [WW:0] w;
        int ch;
        #2;
        cycle++;
        if (cycle > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycle, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
        if (rst_n) begin
            if (pv && !pr)
                check(out_valid && ({out_last, out_data} == pw), "R4", "stalled word held",
                      {out_valid, out_last, out_data}, {1'b1, pw});
            if (out_valid && out_ready) begin
                w  = {out_last, out_data};
                ch = int'(out_data[23:20]);
                if (mid && ch != cur_ch)
                    check(1'b0, "R2", "packet interleave channel", ch, cur_ch);
                if (ch >= NCH || expq[ch].size() == 0) begin
                    check(1'b0, "R2", "unexpected word", w, 0);
                end else begin
                    check(w == expq[ch][0], "R2", "output word", w, expq[ch][0]);
                    void'(expq[ch].pop_front());
                end
                if (out_last) begin
                    // R9: the last word index must match the length field.
                    check(int'(out_data[11:8]) + 1 == int'(out_data[7:0]), "R9",
                          "packet length at last word", out_data[11:8] + 1, out_data[7:0]);
                    done_ch.push_back(ch);
                end
                mid    = !out_last;
                cur_ch = ch;
            end
        end
        pv = out_valid;
        pr = out_ready;
        pw = {out_last, out_data};
    end

    task automatic ld_write(int ch, logic [WW-1:0] data, logic last);
        @(negedge clk);
        ld_en   = 1'b1;
        ld_ch   = 3'(ch);
        ld_data = data;
        ld_last = last;
    endtask

    task automatic ld_idle();
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        while (!all_empty() && n < 40000) begin
            @(negedge clk);
            n++;
        end
        repeat (20) @(negedge clk);
        check(all_empty(), "R2", "all expected words delivered", 0, 0);
    endtask

    // Normal-path sender for one packet on one channel.
    task automatic send_norm(int ch, int seq, int len);
        for (int w = 0; w < len; w++) begin
            @(negedge clk);
            in_valid[ch] = 1'b1;
            in_data[ch*WW +: WW] = mk(ch, seq, w, len);
            in_last[ch] = (w == len - 1);
            #1;
            while (!in_ready[ch]) begin
                @(negedge clk);
                #1;
            end
            expq[ch].push_back({(w == len - 1), mk(ch, seq, w, len)});
        end
    endtask

    task automatic chan_stream(int ch);
        for (int s = 0; s < 6; s++) send_norm(ch, s, 1 + (ch * 3 + s * 7) % 10);
        @(negedge clk);
        in_valid[ch] = 1'b0;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        check(in_ready == '1, "R1", "in_ready after reset", in_ready, 8'hFF);
        check(load_drop == '0, "R1", "load_drop after reset", load_drop, 0);

        // R3: interleave loads to sibling channels 0 and 1 with output stalled.
        fixed_ready = 1'b0;
        for (int p = 0; p < 5; p++)
            for (int w = 0; w < 3; w++) begin
                ld_write(0, mk(0, p, w, 3), w == 2);
                expq[0].push_back({(w == 2), mk(0, p, w, 3)});
                ld_write(1, mk(1, p, w, 3), w == 2);
                expq[1].push_back({(w == 2), mk(1, p, w, 3)});
            end
        ld_idle();
        repeat (40) @(negedge clk);
        done_ch.delete();
        fixed_ready = 1'b1;
        drain();
        check(done_ch.size() == 10, "R3", "packet count", done_ch.size(), 10);
        for (int i = 0; i < done_ch.size(); i++)
            check(done_ch[i] == (i % 2), "R3", "round-robin order", done_ch[i], i % 2);

        // R5/R8/R7: fill channel 2 with single-word packets, output stalled.
        fixed_ready = 1'b0;
        for (int i = 0; i < DEPTH + LEVELS; i++) begin
            ld_write(2, mk(2, i, 0, 1), 1'b1);
            expq[2].push_back({1'b1, mk(2, i, 0, 1)});
        end
        ld_idle();
        #1;
        check(load_drop == '0, "R8", "no drop within queue plus stages", load_drop, 0);
        check(in_ready[2] == 1'b0, "R5", "full queue not ready", in_ready[2], 0);
        check(in_ready[3] == 1'b1, "R5", "other channel still ready", in_ready[3], 1);
        ld_write(2, mk(2, 200, 0, 1), 1'b1);
        ld_idle();
        #1;
        check(load_drop == 8'h04, "R7", "drop flag after extra load", load_drop, 8'h04);
        fixed_ready = 1'b1;
        drain();
        #1;
        check(in_ready[2] == 1'b1, "R5", "ready again after drain", in_ready[2], 1);

        // R2/R4/R9: all channels stream over the normal path, random backpressure.
        rand_mode = 1'b1;
        fork
            chan_stream(0); chan_stream(1); chan_stream(2); chan_stream(3);
            chan_stream(4); chan_stream(5); chan_stream(6); chan_stream(7);
        join
        drain();
        rand_mode = 1'b0;

        // R6: load write and normal write to channel 4 in the same cycle.
        @(negedge clk);
        in_valid[4] = 1'b1;
        in_data[4*WW +: WW] = mk(4, 50, 0, 1);
        in_last[4] = 1'b1;
        ld_en = 1'b1;
        ld_ch = 3'd4;
        ld_data = mk(4, 51, 0, 1);
        ld_last = 1'b1;
        #1;
        check(in_ready[4] == 1'b0, "R6", "targeted channel held off", in_ready[4], 0);
        check(in_ready[5] == 1'b1, "R6", "neighbour channel unaffected", in_ready[5], 1);
        expq[4].push_back({1'b1, mk(4, 51, 0, 1)});
        @(negedge clk);
        ld_en = 1'b0;
        #1;
        check(in_ready[4] == 1'b1, "R6", "channel ready after load", in_ready[4], 1);
        expq[4].push_back({1'b1, mk(4, 50, 0, 1)});
        @(negedge clk);
        in_valid[4] = 1'b0;
        drain();
        check(load_drop == 8'h04, "R7", "drop flag sticky", load_drop, 8'h04);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule